// File: doc/BRIEF.md
# Serial Control Register Port

This block is the slave end of a host-driven synchronous serial link that carries register traffic from a DSP or microcontroller. The host supplies a bit clock, a frame-sync pulse and a receive data line. Every frame is one 16-bit word: a 10-bit data field in the upper bits, a 5-bit register address below it, and a one-bit access flag in the least significant position. The port turns each completed word into a register write or a register read.

One register is mapped. It holds the ramp-up delay, the ramp-down delay and a level-held flag that keeps a burst buffer's write pointer parked at its base address. These fields leave the block as parallel outputs for the logic downstream. A read answers in the frame that follows, using the same 16-bit layout on the transmit line.

All host signals are resynchronised into the system clock domain. The bit clock must therefore run well below the system clock.

Top module: `scp_ctrl_port`

## Requirements
- R1: A frame starts at the bit-clock rising edge where frame sync is high. Sixteen bits are taken MSB first, one on each rising edge. The word completes on the 16th bit. Bits [15:6] are data, bits [5:1] are the address, and bit 0 is the access flag.
- R2: A word with flag 0 and address 1 writes the ramp register. Data bits [3:0] become the ramp-up delay output, bits [7:4] the ramp-down delay output, and bit 8 the pointer-hold output.
- R3: A word with flag 1 is a read. The answer goes out on the transmit line during the next frame, MSB first. Each bit changes after a bit-clock rising edge and is valid at the following falling edge. The answer word is {data[9:0], address[4:0], 1}.
- R4: Data bit 9 of the ramp register is reserved. It reads as 0 even after a write of 1.
- R5: After reset, all three register outputs are 0 and the transmit line is low.
- R6: A write to any address other than 1 changes nothing. A read of such an address answers with a zero data field and the address echoed.
- R7: A read never changes the register contents.
- R8: The pointer-hold output stays at its written level across any number of later frames. It falls only when a write to address 1 clears data bit 8.
- R9: A frame that does not follow a read sends all zeros on the transmit line.
- R10: Bits clocked while no frame is open (after the 16th bit and before the next frame sync) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Host bit clock |
| ser_fs | input | 1 | Host frame sync, high during the first bit |
| ser_rx | input | 1 | Serial data from host |
| ser_tx | output | 1 | Serial read answer to host |
| ramp_up_dly | output | 4 | Ramp-up delay field |
| ramp_dn_dly | output | 4 | Ramp-down delay field |
| buf_ptr_hold | output | 1 | Hold burst buffer pointer at base while high |

## Verification
A corrupted register or a misdecoded address appears on the parallel delay and hold outputs a few system clocks after the final bit of the offending frame. The bench samples those outputs as soon as each frame ends.

A bit-count slip or a broken answer path shows up one frame later as a wrong transmit word. A scoreboard compares every frame's transmit word against a model of the previous frame.

A stale pending answer is caught as a nonzero word in a frame that should be silent.

// File: rtl/scp_pkg.sv
package scp_pkg;
    localparam int DATA_W = 10;
    localparam int ADDR_W = 5;
    localparam int WORD_W = DATA_W + ADDR_W + 1;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int DLY_W  = 4;
    localparam int REG_W  = 2 * DLY_W + 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } scp_word_t;

    typedef struct packed {
        logic             hold;
        logic [DLY_W-1:0] dn;
        logic [DLY_W-1:0] up;
    } ramp_reg_t;

    function automatic scp_word_t make_answer(input logic [DATA_W-1:0] d,
                                              input logic [ADDR_W-1:0] a);
        scp_word_t w;
        w.data = d;
        w.addr = a;
        w.rd   = 1'b1;
        return w;
    endfunction
endpackage

// File: rtl/scp_deser.sv
module scp_deser
    import scp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ser_clk,
    input  logic      ser_fs,
    input  logic      ser_rx,
    output logic      bit_edge,
    output logic      frame_start,
    output logic      word_vld,
    output scp_word_t word
);
    logic [2:0]        clk_s;
    logic [1:0]        fs_s;
    logic [1:0]        rx_s;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_s <= '0;
            fs_s  <= '0;
            rx_s  <= '0;
        end else begin
            clk_s <= {clk_s[1:0], ser_clk};
            fs_s  <= {fs_s[0], ser_fs};
            rx_s  <= {rx_s[0], ser_rx};
        end
    end

    assign bit_edge    = clk_s[1] & ~clk_s[2];
    assign frame_start = bit_edge & fs_s[1];

    always_comb begin
        if (fs_s[1]) cnt_n = CNT_W'(1);
        else         cnt_n = cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            shreg    <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (bit_edge && (fs_s[1] || cnt != '0)) begin
                shreg <= {shreg[WORD_W-2:0], rx_s[1]};
                if (cnt_n == CNT_W'(WORD_W)) begin
                    word_vld <= 1'b1;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt_n;
                end
            end
        end
    end

    assign word = scp_word_t'(shreg);

    assert_vld_follows_edge_R1: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> $past(bit_edge));
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(WORD_W));
    assert_idle_bits_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (bit_edge && !fs_s[1] && cnt == '0) |=> $stable(shreg));
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
    import scp_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAMP_ADDR = ADDR_W'(1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             word_vld,
    input  scp_word_t        word,
    output logic [DLY_W-1:0] ramp_up,
    output logic [DLY_W-1:0] ramp_dn,
    output logic             hold,
    output logic             rsp_vld,
    output scp_word_t        rsp_word
);
    ramp_reg_t          ramp_q;
    logic               hit;
    logic [DATA_W-1:0]  rd_data;

    assign hit     = (word.addr == RAMP_ADDR);
    assign rd_data = hit ? DATA_W'(ramp_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ramp_q <= '0;
        end else if (word_vld && !word.rd && hit) begin
            ramp_q <= ramp_reg_t'(word.data[REG_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld  <= 1'b0;
            rsp_word <= '0;
        end else begin
            rsp_vld <= word_vld && word.rd;
            if (word_vld && word.rd) rsp_word <= make_answer(rd_data, word.addr);
        end
    end

    assign ramp_up = ramp_q.up;
    assign ramp_dn = ramp_q.dn;
    assign hold    = ramp_q.hold;

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> rsp_word.data[DATA_W-1] == 1'b0);
    assert_read_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (word_vld && word.rd) |=> $stable(ramp_q));
    assert_unmapped_write_R6: assert property (@(posedge clk) disable iff (rst)
        (word_vld && !hit) |=> $stable(ramp_q));
    assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_word.addr != RAMP_ADDR) |-> rsp_word.data == '0);
endmodule

// File: rtl/scp_txser.sv
module scp_txser
    import scp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_edge,
    input  logic      frame_start,
    input  logic      rsp_vld,
    input  scp_word_t rsp_word,
    output logic      tx
);
    logic              pend;
    logic [WORD_W-1:0] pend_word;
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_word <= '0;
            shreg     <= '0;
        end else begin
            if (bit_edge) begin
                if (frame_start) begin
                    shreg <= pend ? pend_word : '0;
                    pend  <= 1'b0;
                end else begin
                    shreg <= {shreg[WORD_W-2:0], 1'b0};
                end
            end
            if (rsp_vld) begin
                pend      <= 1'b1;
                pend_word <= rsp_word;
            end
        end
    end

    assign tx = shreg[WORD_W-1];

    assert_silent_frame_R9: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !pend && !rsp_vld) |=> tx == 1'b0);
    assert_answer_msb_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_start && pend) |=> tx == $past(pend_word[WORD_W-1]));
endmodule

// File: rtl/scp_ctrl_port.sv
module scp_ctrl_port
    import scp_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAMP_ADDR = ADDR_W'(1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_fs,
    input  logic             ser_rx,
    output logic             ser_tx,
    output logic [DLY_W-1:0] ramp_up_dly,
    output logic [DLY_W-1:0] ramp_dn_dly,
    output logic             buf_ptr_hold
);
    logic      bit_edge;
    logic      frame_start;
    logic      word_vld;
    scp_word_t word;
    logic      rsp_vld;
    scp_word_t rsp_word;

    scp_deser u_deser (
        .clk         (clk),
        .rst         (rst),
        .ser_clk     (ser_clk),
        .ser_fs      (ser_fs),
        .ser_rx      (ser_rx),
        .bit_edge    (bit_edge),
        .frame_start (frame_start),
        .word_vld    (word_vld),
        .word        (word)
    );

    scp_regfile #(.RAMP_ADDR(RAMP_ADDR)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .word_vld (word_vld),
        .word     (word),
        .ramp_up  (ramp_up_dly),
        .ramp_dn  (ramp_dn_dly),
        .hold     (buf_ptr_hold),
        .rsp_vld  (rsp_vld),
        .rsp_word (rsp_word)
    );

    scp_txser u_tx (
        .clk         (clk),
        .rst         (rst),
        .bit_edge    (bit_edge),
        .frame_start (frame_start),
        .rsp_vld     (rsp_vld),
        .rsp_word    (rsp_word),
        .tx          (ser_tx)
    );

    assert_hold_level_R8: assert property (@(posedge clk) disable iff (rst)
        (!word_vld && !$past(word_vld)) |-> $stable(buf_ptr_hold));
endmodule

// File: tb/scp_ctrl_port_tb_top.sv
module scp_ctrl_port_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_fs = 1'b0;
    logic       ser_rx = 1'b0;
    logic       ser_tx;
    logic [3:0] ramp_up_dly;
    logic [3:0] ramp_dn_dly;
    logic       buf_ptr_hold;

    int n_run = 0;
    int n_fail = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] cur_exp = 16'h0;
    logic [8:0]  mreg = 9'h0;
    logic [15:0] mon_w;
    logic [15:0] mon_e;
    string       mon_t;

    always #5 clk = ~clk;

    scp_ctrl_port dut_i (
        .clk          (clk),
        .rst          (rst),
        .ser_clk      (ser_clk),
        .ser_fs       (ser_fs),
        .ser_rx       (ser_rx),
        .ser_tx       (ser_tx),
        .ramp_up_dly  (ramp_up_dly),
        .ramp_dn_dly  (ramp_dn_dly),
        .buf_ptr_hold (buf_ptr_hold)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] wr_w(input logic [4:0] a, input logic [9:0] d);
        return {d, a, 1'b0};
    endfunction

    function automatic logic [15:0] rd_w(input logic [4:0] a);
        return {10'h0, a, 1'b1};
    endfunction

    task automatic check_outs(input string tag);
        check(tag, {7'h0, buf_ptr_hold, ramp_dn_dly, ramp_up_dly}, {7'h0, mreg});
    endtask

    // driver: pushes the expected transmit word, then clocks the frame out
    task automatic send(input logic [15:0] w, input logic use_fs);
        if (use_fs) begin
            exp_q.push_back(cur_exp);
            tag_q.push_back(cur_exp == 16'h0 ? "R9 silent frame" : "R3 read answer");
        end
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            ser_rx = w[i];
            ser_fs = use_fs && (i == 15);
            repeat (8) @(negedge clk);
            ser_clk = 1'b1;
            repeat (8) @(negedge clk);
            ser_clk = 1'b0;
        end
        @(negedge clk);
        ser_fs = 1'b0;
        ser_rx = 1'b0;
        repeat (4) @(negedge clk);
        if (use_fs) begin
            if (!w[0] && w[5:1] == 5'd1) mreg = w[14:6];
            if (w[0]) cur_exp = {(w[5:1] == 5'd1) ? {1'b0, mreg} : 10'h0, w[5:1], 1'b1};
            else      cur_exp = 16'h0;
        end
    endtask

    // monitor: collects each transmitted word and compares with the queue
    initial begin
        forever begin
            @(posedge ser_clk);
            if (ser_fs) begin
                mon_w = 16'h0;
                for (int k = 0; k < 16; k++) begin
                    @(negedge ser_clk);
                    mon_w = {mon_w[14:0], ser_tx};
                end
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                check(mon_t, mon_w, mon_e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R5 reset outputs", {7'h0, buf_ptr_hold, ramp_dn_dly, ramp_up_dly}, 16'h0);
        check("R5 reset tx", {15'h0, ser_tx}, 16'h0);

        send(wr_w(5'd1, 10'h0A5), 1'b1);
        check_outs("R2 write ramp fields");
        send(rd_w(5'd1), 1'b1);
        check_outs("R7 read leaves register");
        send(wr_w(5'd1, 10'h3FF), 1'b1);       // tx carries the 0x0A5 answer
        check_outs("R2 R4 write all ones");
        send(rd_w(5'd1), 1'b1);
        send(rd_w(5'd7), 1'b1);                 // answers reserved bit as 0 (R4)
        check_outs("R8 hold kept across reads");
        send(wr_w(5'd7, 10'h000), 1'b1);        // answers unmapped read (R6)
        check_outs("R6 unmapped write ignored");
        send(rd_w(5'd0), 1'b1);
        send(wr_w(5'd1, 10'h000), 1'b0);        // no frame sync: ignored
        check_outs("R10 idle bits ignored");
        send(wr_w(5'd1, 10'h0C3), 1'b1);
        check_outs("R8 hold cleared by write");
        send(wr_w(5'd1, 10'h1E1), 1'b1);
        check_outs("R1 R2 new field values");
        send(rd_w(5'd1), 1'b1);
        send(rd_w(5'd31), 1'b1);
        send(rd_w(5'd1), 1'b1);
        send(wr_w(5'd2, 10'h155), 1'b1);
        check_outs("R6 second unmapped write");
        send(wr_w(5'd0, 10'h0), 1'b1);

        repeat (10) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule